// File: doc/BRIEF.md
# Two-stage SCL rate divider

This block derives the bit timing of a two-wire serial master from a fast system clock. Software writes a 7-bit rate value. Its upper four bits are a linear factor M and its lower three bits are an exponent N. The divider first divides the clock by 2^(N+1) in a power-of-two stage. It then counts (M+1) outputs of that stage in a linear stage. The result is a tick stream that runs at ten times the SCL rate.

A phase sequencer counts ten ticks per SCL period and drives the SCL level. It also issues three strobes for the bus engine: one where SDA may change (centre of the low half), one where SDA is sampled (centre of the high half), and one at the start of each period. A rate value written in the middle of a period is held back and takes effect at the next period boundary, so no period is ever cut short or stretched by a reprogram. A synchronous soft reset returns the rate register and all timing state to their power-up values.

Top module: `scl_rate_divider`

## Requirements
- R1: After reset the rate register reads 0x44 (M=8, N=4), SCL is low, and tick_o and every strobe are low.
- R2: A value written with baud_wr is returned on baud_o from the cycle after the write. Without a write or soft reset, baud_o holds its value.
- R3: Once a rate value is active, consecutive tick_o pulses are exactly (M+1)*2^(N+1) clock cycles apart, with M = value[6:3] and N = value[2:0]. The first tick after reset or soft reset arrives that many cycles after the release.
- R4: Every tenth tick starts a new SCL period. period_stb_o pulses together with the tick that enters phase 0, and SCL falls only on such a tick.
- R5: SCL is low during phases 0 to 4 and high during phases 5 to 9, and it changes only together with a tick.
- R6: drive_stb_o pulses with the tick that enters phase 2, and sample_stb_o pulses with the tick that enters phase 7. No more than one strobe is high in any cycle, and none is high without a tick.
- R7: A rate value written during a period does not change the remaining ticks of that period. It governs the tick spacing from the period boundary onwards. When several writes land in one period, the last one is used.
- R8: A soft reset returns baud_o to 0x44 in the next cycle, forces SCL low, and restarts the timing from phase 0 at the default rate.
- R9: tick_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset to power-up values |
| baud_wr | input | 1 | Write strobe for the rate register |
| baud_wdata | input | 7 | Rate value, M in bits 6:3 and N in bits 2:0 |
| baud_o | output | 7 | Programmed rate value readback |
| tick_o | output | 1 | One-cycle pulse at ten times the SCL rate |
| scl_o | output | 1 | SCL level, low in phases 0 to 4 |
| drive_stb_o | output | 1 | Pulse at the centre of the SCL low half |
| sample_stb_o | output | 1 | Pulse at the centre of the SCL high half |
| period_stb_o | output | 1 | Pulse at the start of each SCL period |

## Verification
The bench uses the default parameters: a 4-bit M, a 3-bit N, ten ticks per period and a reset value of 0x44. With these values both ends of the range fit in the cycle budget: rate 0x00 gives a two-cycle tick, and rate 0x7F gives a 4096-cycle tick, so the bench can show the prescalers at their shortest and longest. Rate changes are written in phases 0, 1 and 2. This places old-rate ticks before the boundary and new-rate ticks after it, with different spacing on each side, so a change that takes effect early or late shows up as a wrong interval. A double write within one period and a soft reset after a non-default rate cover the last-write-wins and default-restore rules.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    localparam int unsigned DEF_LIN_W = 4;
    localparam int unsigned DEF_EXP_W = 3;
    localparam int unsigned DEF_TICKS = 10;
    localparam logic [6:0]  DEF_RESET_BAUD = 7'h44;
endpackage

// File: rtl/scl_baud_reg.sv
// Rate register plus the shadow copy that the prescalers actually use.
module scl_baud_reg #(
    parameter int unsigned BAUD_W = 7,
    parameter logic [BAUD_W-1:0] RESET_BAUD = 'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [BAUD_W-1:0] wr_data,
    input  logic              load,
    output logic [BAUD_W-1:0] prog_o,
    output logic [BAUD_W-1:0] active_o
);
    typedef struct packed {
        logic [BAUD_W-1:0] prog;
        logic [BAUD_W-1:0] active;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.prog = wr_data;
        // the shadow copy follows only at a period boundary
        if (load) st_d.active = st_q.prog;
        if (soft_rst) begin
            st_d.prog   = RESET_BAUD;
            st_d.active = RESET_BAUD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prog   <= RESET_BAUD;
            st_q.active <= RESET_BAUD;
        end else begin
            st_q <= st_d;
        end
    end

    assign prog_o   = st_q.prog;
    assign active_o = st_q.active;
endmodule

// File: rtl/scl_pow2_stage.sv
// Free-running counter; pulses when its low N+1 bits are all ones,
// i.e. once every 2^(N+1) cycles.
module scl_pow2_stage #(
    parameter int unsigned EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             clr,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             pulse_o
);
    localparam int unsigned CNT_W = 1 << EXP_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic [CNT_W-1:0] mask;

    // bit i of the mask is set for every i up to N
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = (EXP_W'(i) <= exp_sel);
    end

    assign pulse_o = ((st_q.cnt & mask) == mask);

    always_comb begin
        st_d = st_q;
        if (clr || soft_rst) st_d.cnt = '0;
        else                 st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/scl_lin_stage.sv
// Counts M+1 power-of-two pulses and emits one tick event on the last.
module scl_lin_stage #(
    parameter int unsigned LIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             step,
    input  logic [LIN_W-1:0] lin_sel,
    output logic             tick_ev_o
);
    typedef struct packed {
        logic [LIN_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    assign tick_ev_o = step && (st_q.cnt == lin_sel);

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (tick_ev_o) st_d.cnt = '0;
            else           st_d.cnt = st_q.cnt + 1'b1;
        end
        if (soft_rst) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/scl_phase_seq.sv
// Ten-phase sequencer: SCL level and the drive, sample and period strobes.
module scl_phase_seq #(
    parameter int unsigned TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic tick_ev,
    output logic wrap_o,
    output logic tick_o,
    output logic scl_o,
    output logic drive_o,
    output logic sample_o,
    output logic period_o
);
    localparam int unsigned PH_W = $clog2(TICKS);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(TICKS - 1);
    localparam logic [PH_W-1:0] HIGH_PH = PH_W'(TICKS / 2);
    localparam logic [PH_W-1:0] DRV_PH  = PH_W'(TICKS / 4);
    localparam logic [PH_W-1:0] SMP_PH  = PH_W'(TICKS / 2 + TICKS / 4);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            tick;
        logic            scl;
        logic            drive;
        logic            sample;
        logic            period;
    } state_t;

    state_t st_d, st_q;
    logic [PH_W-1:0] nxt_ph;

    assign wrap_o = tick_ev && (st_q.phase == LAST_PH);

    always_comb begin
        st_d        = st_q;
        st_d.tick   = 1'b0;
        st_d.drive  = 1'b0;
        st_d.sample = 1'b0;
        st_d.period = 1'b0;
        nxt_ph      = wrap_o ? '0 : st_q.phase + 1'b1;
        if (tick_ev) begin
            st_d.phase  = nxt_ph;
            st_d.tick   = 1'b1;
            st_d.scl    = (nxt_ph >= HIGH_PH);
            st_d.drive  = (nxt_ph == DRV_PH);
            st_d.sample = (nxt_ph == SMP_PH);
            st_d.period = (nxt_ph == '0);
        end
        if (soft_rst) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o   = st_q.tick;
    assign scl_o    = st_q.scl;
    assign drive_o  = st_q.drive;
    assign sample_o = st_q.sample;
    assign period_o = st_q.period;
endmodule

// File: rtl/scl_rate_divider.sv
module scl_rate_divider #(
    parameter int unsigned LIN_W = scl_div_pkg::DEF_LIN_W,
    parameter int unsigned EXP_W = scl_div_pkg::DEF_EXP_W,
    parameter int unsigned TICKS = scl_div_pkg::DEF_TICKS,
    parameter logic [LIN_W+EXP_W-1:0] RESET_BAUD = scl_div_pkg::DEF_RESET_BAUD
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic                   baud_wr,
    input  logic [LIN_W+EXP_W-1:0] baud_wdata,
    output logic [LIN_W+EXP_W-1:0] baud_o,
    output logic                   tick_o,
    output logic                   scl_o,
    output logic                   drive_stb_o,
    output logic                   sample_stb_o,
    output logic                   period_stb_o
);
    localparam int unsigned BAUD_W = LIN_W + EXP_W;

    logic [BAUD_W-1:0] prog_w;
    logic [BAUD_W-1:0] active_w;
    logic              pow_pulse;
    logic              tick_ev;
    logic              wrap;

    scl_baud_reg #(.BAUD_W(BAUD_W), .RESET_BAUD(RESET_BAUD)) u_baud (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(baud_wr), .wr_data(baud_wdata), .load(wrap),
        .prog_o(prog_w), .active_o(active_w)
    );

    // cleared on every tick so a larger N never starts mid-count
    scl_pow2_stage #(.EXP_W(EXP_W)) u_pow (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clr(tick_ev),
        .exp_sel(active_w[EXP_W-1:0]), .pulse_o(pow_pulse)
    );

    scl_lin_stage #(.LIN_W(LIN_W)) u_lin (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .step(pow_pulse),
        .lin_sel(active_w[BAUD_W-1:EXP_W]), .tick_ev_o(tick_ev)
    );

    scl_phase_seq #(.TICKS(TICKS)) u_phase (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick_ev(tick_ev),
        .wrap_o(wrap), .tick_o(tick_o), .scl_o(scl_o),
        .drive_o(drive_stb_o), .sample_o(sample_stb_o), .period_o(period_stb_o)
    );

    assign baud_o = prog_w;
endmodule

// File: rtl/scl_rate_divider_chk.sv
module scl_rate_divider_chk #(
    parameter int unsigned BAUD_W = 7,
    parameter logic [BAUD_W-1:0] RESET_BAUD = 'h44
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              baud_wr,
    input logic [BAUD_W-1:0] baud_o,
    input logic              tick_o,
    input logic              scl_o,
    input logic              drive_stb_o,
    input logic              sample_stb_o,
    input logic              period_stb_o
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_wr && !soft_rst) |=> $stable(baud_o));

    p_fall_at_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_o) && !$past(soft_rst)) |-> period_stb_o);

    p_scl_moves_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(scl_o) && !$past(soft_rst)) |-> tick_o);

    p_rise_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_o) |-> !(drive_stb_o || sample_stb_o || period_stb_o));

    p_strobe_with_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_stb_o || sample_stb_o || period_stb_o) |-> tick_o);

    p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drive_stb_o, sample_stb_o, period_stb_o}));

    p_soft_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (baud_o == RESET_BAUD && !scl_o && !tick_o));

    p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

bind scl_rate_divider scl_rate_divider_chk #(
    .BAUD_W(BAUD_W), .RESET_BAUD(RESET_BAUD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .baud_wr(baud_wr),
    .baud_o(baud_o), .tick_o(tick_o), .scl_o(scl_o),
    .drive_stb_o(drive_stb_o), .sample_stb_o(sample_stb_o),
    .period_stb_o(period_stb_o)
);

// File: tb/scl_rate_divider_bench.sv
module scl_rate_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n, soft_rst, baud_wr;
    logic [6:0] baud_wdata, baud_o;
    logic       tick_o, scl_o, drive_stb_o, sample_stb_o, period_stb_o;

    always #4 clk = ~clk;

    scl_rate_divider u_scl_rate_divider (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .baud_wr(baud_wr),
        .baud_wdata(baud_wdata), .baud_o(baud_o), .tick_o(tick_o),
        .scl_o(scl_o), .drive_stb_o(drive_stb_o),
        .sample_stb_o(sample_stb_o), .period_stb_o(period_stb_o)
    );

    typedef struct {
        int    interval;
        int    phase;
        string req;
    } exp_t;

    exp_t       sb_q[$];
    exp_t       mon_r;
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    int         last = 0;
    bit         rst_mark = 1'b0;
    bit         prev_tick = 1'b0;
    logic [6:0] exp_active, exp_prog;
    int         plan_phase;

    function automatic int d_of(logic [6:0] v);
        return (int'(v[6:3]) + 1) * (1 << (int'(v[2:0]) + 1));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // driver side: push expected ticks from the bench's own rate model
    task automatic plan(int n, string req);
        for (int i = 0; i < n; i++) begin
            exp_t r;
            plan_phase = (plan_phase + 1) % 10;
            r.interval = d_of(exp_active);
            r.phase    = plan_phase;
            r.req      = req;
            sb_q.push_back(r);
            if (plan_phase == 0) exp_active = exp_prog;
        end
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(posedge clk);
        #1;
    endtask

    task automatic write_plan(logic [6:0] v, int n, string req);
        drain();
        baud_wr = 1'b1; baud_wdata = v; exp_prog = v;
        plan(n, req);
        @(posedge clk); #1;
        baud_wr = 1'b0;
        check(baud_o == v, "R2", "baud readback", int'(baud_o), int'(v));
    endtask

    // monitor side: measure tick spacing and phase outputs
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                cyc++;
                if (rst_mark) begin last = cyc; rst_mark = 1'b0; end
                if (tick_o) begin
                    check(!prev_tick, "R9", "tick width", 2, 1);
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R3", "unexpected tick", 1, 0);
                    end else begin
                        mon_r = sb_q.pop_front();
                        check(cyc - last == mon_r.interval, mon_r.req,
                              "tick interval", cyc - last, mon_r.interval);
                        check(scl_o == (mon_r.phase >= 5), "R5", "scl level",
                              int'(scl_o), int'(mon_r.phase >= 5));
                        check(drive_stb_o == (mon_r.phase == 2), "R6", "drive strobe",
                              int'(drive_stb_o), int'(mon_r.phase == 2));
                        check(sample_stb_o == (mon_r.phase == 7), "R6", "sample strobe",
                              int'(sample_stb_o), int'(mon_r.phase == 7));
                        check(period_stb_o == (mon_r.phase == 0), "R4", "period strobe",
                              int'(period_stb_o), int'(mon_r.phase == 0));
                    end
                    last = cyc;
                end
                prev_tick = tick_o;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; soft_rst = 1'b0; baud_wr = 1'b0; baud_wdata = '0;
        exp_active = 7'h44; exp_prog = 7'h44; plan_phase = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(baud_o == 7'h44, "R1", "reset baud", int'(baud_o), 'h44);
        check(!scl_o, "R1", "reset scl", int'(scl_o), 0);
        check(!tick_o, "R1", "reset tick", int'(tick_o), 0);
        check(!(drive_stb_o || sample_stb_o || period_stb_o), "R1",
              "reset strobes", int'(drive_stb_o | sample_stb_o | period_stb_o), 0);
        plan(12, "R3");
        #1 rst_n = 1'b1;

        // fastest rate, written in phase 2: old spacing until boundary (R7)
        write_plan(7'h00, 30, "R7");
        // slowest rate
        write_plan(7'h7F, 19, "R3");
        // M=1 N=3 written in phase 1
        write_plan(7'h0B, 29, "R7");

        // two writes in one period: last one wins (R7)
        drain();
        baud_wr = 1'b1; baud_wdata = 7'h01; exp_prog = 7'h01;
        @(posedge clk); #1;
        baud_wdata = 7'h19; exp_prog = 7'h19;
        plan(20, "R7");
        @(posedge clk); #1;
        baud_wr = 1'b0;
        check(baud_o == 7'h19, "R2", "baud after double write", int'(baud_o), 'h19);

        // soft reset restores default rate and phase 0 (R8)
        drain();
        soft_rst = 1'b1;
        @(posedge clk); #1;
        soft_rst = 1'b0;
        rst_mark = 1'b1;
        exp_active = 7'h44; exp_prog = 7'h44; plan_phase = 0;
        check(baud_o == 7'h44, "R8", "soft reset baud", int'(baud_o), 'h44);
        check(!scl_o, "R8", "soft reset scl", int'(scl_o), 0);
        check(!tick_o, "R8", "soft reset tick", int'(tick_o), 0);
        plan(10, "R8");

        drain();
        check(sb_q.size() == 0, "R3", "pending ticks", sb_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule